// File: doc/BRIEF.md
# ADC Two-Point Calibration Datapath

This block turns raw 12-bit converter codes into scaled engineering values, such as millivolts, for up to sixteen input channels. Each channel holds three signed coefficients: a gain-error factor, a gain and an offset. A calibrate command loads them. It carries the channel's two factory trim codes (lower and upper), the two ideal codes at which those trims were taken, and the two values expected at those codes. The block derives the coefficients and stores them for that channel. A correct command then takes a raw code and returns the corrected value. It removes the trim offset, divides by the gain-error factor (scaled by 1000), and applies the ideal gain. Results below zero are clamped to zero.

Commands enter on a valid/ready port and results leave on a second valid/ready port. The block handles one command at a time. `cmd_ready` is high only while the block is idle with no result waiting. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The result then waits on `res_valid` until the consumer raises `res_ready`, and while it waits the block accepts nothing new. Both commands use one shared restoring signed divider. Every command therefore has the same fixed latency. A parameter mask marks channels that have no trim data. Those channels skip the error correction and apply only the gain.

Top module: `adc_cal_core`

## Requirements
- R1: `cmd_ready` is 1 exactly when the block is idle with no pending result. A command is accepted on a rising edge with `cmd_valid`=1 and `cmd_ready`=1, and each accepted command yields exactly one result beat. `cmd_op`=0 selects calibrate and `cmd_op`=1 selects correct.
- R2: While `res_valid`=1 and `res_ready`=0, `res_valid`, `res_data`, `res_err` and `res_mismatch` hold their values. The beat completes on the first edge with `res_ready`=1, and `cmd_ready` is 1 in the next cycle.
- R3: `res_valid` rises exactly 2·DW+3 clock edges after the accepting edge (67 with DW=32), for both commands.
- R4: Calibrate with x1≠x2 stores three terms for the channel. The gain-error term is k = 1000 + (1000·(d2−d1))/(x2−x1). The gain is g = ((v2−v1)·1000)/(x2−x1). The offset is o = 1000·d1 − (k−1000)·x1. Every division truncates toward zero. The result beat returns g with `res_err`=0. Trim codes are signed two's complement; codes and values are unsigned.
- R5: Correct on a loaded channel that is not in the mask computes t = (1000·raw − o)/k. When t ≥ 0 it returns (t·g)/1000, truncated toward zero.
- R6: When t < 0, the result is 0. `res_mismatch`=1 exactly when t < −10 on such a channel; otherwise it is 0.
- R7: For a channel in UNCAL_MASK (default bits 11, 12, 13 and 15 set), correct returns (raw·g)/1000 using the last stored g, with `res_err`=0 and `res_mismatch`=0.
- R8: Calibrate with x1=x2 returns `res_data`=0 and `res_err`=1, and leaves that channel's stored terms unchanged.
- R9: Correct returns `res_data`=0 and `res_err`=1 in two cases: a channel outside the mask that was never calibrated, or a stored k of 0.
- R10: Calibrating one channel leaves every other channel's terms unchanged.
- R11: After reset, `cmd_ready`=1, `res_valid`=0, no channel is loaded and every stored gain is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 1 | 0 = calibrate, 1 = correct |
| cmd_chan | input | CH_W (4) | Channel index |
| cmd_raw | input | CODE_W (12) | Raw code (correct) |
| cmd_x1 | input | CODE_W (12) | Lower ideal code (calibrate) |
| cmd_x2 | input | CODE_W (12) | Upper ideal code (calibrate) |
| cmd_v1 | input | VAL_W (16) | Expected value at lower code |
| cmd_v2 | input | VAL_W (16) | Expected value at upper code |
| cmd_d1 | input | TRIM_W (16) | Lower trim code, signed |
| cmd_d2 | input | TRIM_W (16) | Upper trim code, signed |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Consumer takes result |
| res_data | output | DW (32) | Gain (calibrate) or corrected value (correct) |
| res_err | output | 1 | Division by zero or missing calibration |
| res_mismatch | output | 1 | Intermediate value below −10 |

## Verification
The embedded properties check the following on every cycle:
- results hold steady under back-pressure;
- `cmd_ready` is never high while a result is pending;
- the accept-to-result latency is fixed;
- the divider's done pulse is one cycle wide;
- a clamped or errored result carries zero data;
- masked channels never flag a mismatch;
- a rejected or absent write leaves the loaded set untouched.

The arithmetic itself can only be shown by the bench's scenarios. These cover truncation of negative quotients, the boundary between t = 0 and the clamp, the −10 mismatch threshold, a zero gain-error factor, equal ideal codes, and isolation between channels.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam logic OP_CAL = 1'b0;
  localparam logic OP_FIX = 1'b1;
  localparam int   SCALE  = 1000;
  localparam int   MIS_LIMIT = -10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FIRST,
    ST_SECOND,
    ST_RESP
  } cal_state_e;
endpackage

// File: rtl/adc_cal_div.sv
module adc_cal_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic         dz,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic          neg_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  num_abs, den_abs, rem_sh, rem_dif;
  logic          take;

  always_comb begin
    num_abs = num[W-1] ? (~num + 1'b1) : num;
    den_abs = den[W-1] ? (~den + 1'b1) : den;
    rem_sh  = {rem_q[W-2:0], quo_q[W-1]};
    take    = (rem_sh >= dvs_q);
    rem_dif = rem_sh - dvs_q;
    quot    = neg_q ? (~quo_q + 1'b1) : quo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      neg_q <= 1'b0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      dz    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= num_abs;
        dvs_q <= den_abs;
        neg_q <= num[W-1] ^ den[W-1];
        dz    <= (den == '0);
        cnt_q <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= take ? rem_dif : rem_sh;
        quo_q <= {quo_q[W-2:0], take};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DIV_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R3
  AST_DIV_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R3
endmodule

// File: rtl/adc_cal_coef.sv
module adc_cal_coef #(
  parameter int NCH  = 16,
  parameter int CH_W = 4,
  parameter int W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [W-1:0]    wr_k,
  input  logic [W-1:0]    wr_gain,
  input  logic [W-1:0]    wr_off,
  input  logic [CH_W-1:0] rd_ch,
  output logic [W-1:0]    rd_k,
  output logic [W-1:0]    rd_gain,
  output logic [W-1:0]    rd_off,
  output logic            rd_loaded
);
  logic [W-1:0]   k_a    [NCH];
  logic [W-1:0]   gain_a [NCH];
  logic [W-1:0]   off_a  [NCH];
  logic [NCH-1:0] loaded_v;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        k_a[g]      <= '0;
        gain_a[g]   <= '0;
        off_a[g]    <= '0;
        loaded_v[g] <= 1'b0;
      end else if (wr_en && (wr_ch == CH_W'(g))) begin
        k_a[g]      <= wr_k;
        gain_a[g]   <= wr_gain;
        off_a[g]    <= wr_off;
        loaded_v[g] <= 1'b1;
      end
    end
  end

  assign rd_k      = k_a[rd_ch];
  assign rd_gain   = gain_a[rd_ch];
  assign rd_off    = off_a[rd_ch];
  assign rd_loaded = loaded_v[rd_ch];

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(loaded_v)); // R8
  AST_COEF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($countones(loaded_v ^ $past(loaded_v)) <= 1)); // R10
endmodule

// File: rtl/adc_cal_core.sv
module adc_cal_core
  import adc_cal_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int CODE_W = 12,
  parameter int TRIM_W = 16,
  parameter int VAL_W  = 16,
  parameter int DW     = 32,
  parameter logic [NCH-1:0] UNCAL_MASK = NCH'(16'hB800),
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic [CODE_W-1:0] cmd_raw,
  input  logic [CODE_W-1:0] cmd_x1,
  input  logic [CODE_W-1:0] cmd_x2,
  input  logic [VAL_W-1:0]  cmd_v1,
  input  logic [VAL_W-1:0]  cmd_v2,
  input  logic [TRIM_W-1:0] cmd_d1,
  input  logic [TRIM_W-1:0] cmd_d2,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DW-1:0]     res_data,
  output logic              res_err,
  output logic              res_mismatch
);
  localparam int LAT = 2 * DW + 3;
  localparam int LCW = $clog2(LAT + 2) + 1;
  localparam logic signed [DW-1:0] K1000 = DW'(SCALE);

  cal_state_e state_q;
  logic              op_q, dz1_q;
  logic [CH_W-1:0]   ch_q;
  logic [CODE_W-1:0] raw_q, x1_q, x2_q;
  logic [VAL_W-1:0]  v1_q, v2_q;
  logic [TRIM_W-1:0] d1_q, d2_q;
  logic signed [DW-1:0] q1_q;

  // divider and coefficient store connections
  logic          div_start, div_busy, div_done, div_dz;
  logic [DW-1:0] div_num, div_den, div_quot;
  logic          wr_en, rd_loaded;
  logic [DW-1:0] rd_k, rd_gain, rd_off;

  logic signed [DW-1:0] d1_s, d2_s, x1_s, x2_s, v1_s, v2_s, raw_s, dx_s;
  logic signed [DW-1:0] num1, den1, num2, den2, k_new, off_new;
  logic signed [DW-1:0] quot_s, k_s, gain_s, off_s;
  logic uncal, fix_err, t_neg, mis_hit;

  always_comb begin
    d1_s   = DW'($signed(d1_q));
    d2_s   = DW'($signed(d2_q));
    x1_s   = DW'(x1_q);
    x2_s   = DW'(x2_q);
    v1_s   = DW'(v1_q);
    v2_s   = DW'(v2_q);
    raw_s  = DW'(raw_q);
    dx_s   = x2_s - x1_s;
    quot_s = div_quot;
    k_s    = rd_k;
    gain_s = rd_gain;
    off_s  = rd_off;
    uncal  = UNCAL_MASK[ch_q];
    if (op_q == OP_CAL) begin
      num1 = (d2_s - d1_s) * K1000;
      den1 = dx_s;
      num2 = (v2_s - v1_s) * K1000;
      den2 = dx_s;
    end else begin
      num1 = uncal ? raw_s : (raw_s * K1000 - off_s);
      den1 = uncal ? DW'(1) : k_s;
      num2 = quot_s * gain_s;
      den2 = K1000;
    end
    div_start = (state_q == ST_LOAD) || (state_q == ST_FIRST && div_done);
    div_num   = (state_q == ST_FIRST) ? num2 : num1;
    div_den   = (state_q == ST_FIRST) ? den2 : den1;
    k_new     = K1000 + q1_q;
    off_new   = d1_s * K1000 - q1_q * x1_s;
    fix_err   = (!uncal && !rd_loaded) || dz1_q;
    t_neg     = q1_q[DW-1];
    mis_hit   = !uncal && !fix_err && (q1_q < DW'(MIS_LIMIT));
    wr_en     = (state_q == ST_SECOND) && div_done && (op_q == OP_CAL) && !dz1_q;
    cmd_ready = (state_q == ST_IDLE);
    res_valid = (state_q == ST_RESP);
  end

  adc_cal_div #(.W(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .done  (div_done),
    .dz    (div_dz),
    .quot  (div_quot)
  );

  adc_cal_coef #(.NCH(NCH), .CH_W(CH_W), .W(DW)) u_coef (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_ch     (ch_q),
    .wr_k      (k_new),
    .wr_gain   (div_quot),
    .wr_off    (off_new),
    .rd_ch     (ch_q),
    .rd_k      (rd_k),
    .rd_gain   (rd_gain),
    .rd_off    (rd_off),
    .rd_loaded (rd_loaded)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      op_q         <= OP_CAL;
      ch_q         <= '0;
      raw_q        <= '0;
      x1_q         <= '0;
      x2_q         <= '0;
      v1_q         <= '0;
      v2_q         <= '0;
      d1_q         <= '0;
      d2_q         <= '0;
      q1_q         <= '0;
      dz1_q        <= 1'b0;
      res_data     <= '0;
      res_err      <= 1'b0;
      res_mismatch <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          ch_q    <= cmd_chan;
          raw_q   <= cmd_raw;
          x1_q    <= cmd_x1;
          x2_q    <= cmd_x2;
          v1_q    <= cmd_v1;
          v2_q    <= cmd_v2;
          d1_q    <= cmd_d1;
          d2_q    <= cmd_d2;
          state_q <= ST_LOAD;
        end
        ST_LOAD: state_q <= ST_FIRST;
        ST_FIRST: if (div_done) begin
          q1_q    <= div_quot;
          dz1_q   <= div_dz;
          state_q <= ST_SECOND;
        end
        ST_SECOND: if (div_done) begin
          if (op_q == OP_CAL) begin
            res_data     <= dz1_q ? '0 : div_quot;
            res_err      <= dz1_q;
            res_mismatch <= 1'b0;
          end else begin
            res_data     <= (fix_err || t_neg) ? '0 : div_quot;
            res_err      <= fix_err;
            res_mismatch <= mis_hit;
          end
          state_q <= ST_RESP;
        end
        ST_RESP: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // latency window counter used only by the checks below
  logic [LCW-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (cmd_valid && cmd_ready) lat_cnt <= '0;
    else if (lat_cnt != '1) lat_cnt <= lat_cnt + 1'b1;
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !res_valid); // R1
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)
      && $stable(res_err) && $stable(res_mismatch))); // R2
  AST_FIXED_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (lat_cnt == LCW'(LAT))); // R3
  AST_CLAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mismatch) |-> (res_data == '0)); // R6
  AST_UNCAL_NO_MIS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && UNCAL_MASK[ch_q]) |-> !res_mismatch); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_data == '0)); // R9
endmodule

// File: tb/adc_cal_core_test.sv
module adc_cal_core_test;
  localparam int LAT = 67;
  localparam logic [15:0] UNC = 16'hB800;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_op = 1'b0, res_ready = 1'b0;
  logic [3:0]  cmd_chan = '0;
  logic [11:0] cmd_raw = '0, cmd_x1 = '0, cmd_x2 = '0;
  logic [15:0] cmd_v1 = '0, cmd_v2 = '0, cmd_d1 = '0, cmd_d2 = '0;
  logic        cmd_ready, res_valid, res_err, res_mismatch;
  logic [31:0] res_data;

  adc_cal_core uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_raw(cmd_raw),
    .cmd_x1(cmd_x1), .cmd_x2(cmd_x2), .cmd_v1(cmd_v1), .cmd_v2(cmd_v2),
    .cmd_d1(cmd_d1), .cmd_d2(cmd_d2), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_err(res_err),
    .res_mismatch(res_mismatch)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R11";

  // behavioural reference state
  bit     m_ready = 1'b1, m_rv = 1'b0, m_err = 1'b0, m_mis = 1'b0;
  int     m_cnt = 0;
  longint m_data = 0;
  longint mk[16], mg[16], mo[16];
  bit     mld[16];

  initial for (int i = 0; i < 16; i++) begin
    mk[i] = 0; mg[i] = 0; mo[i] = 0; mld[i] = 1'b0;
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model_accept();
    int ch;
    longint dx, q1, t, raw;
    ch = int'(cmd_chan);
    m_err = 1'b0; m_mis = 1'b0; m_data = 0;
    if (cmd_op == 1'b0) begin
      dx = longint'(cmd_x2) - longint'(cmd_x1);
      if (dx == 0) begin
        m_err = 1'b1;
      end else begin
        q1 = (1000 * (longint'($signed(cmd_d2)) - longint'($signed(cmd_d1)))) / dx;
        mk[ch] = 1000 + q1;
        mg[ch] = ((longint'(cmd_v2) - longint'(cmd_v1)) * 1000) / dx;
        mo[ch] = longint'($signed(cmd_d1)) * 1000 - (mk[ch] - 1000) * longint'(cmd_x1);
        mld[ch] = 1'b1;
        m_data = mg[ch];
      end
    end else begin
      raw = longint'(cmd_raw);
      if (UNC[ch]) begin
        m_data = (raw * mg[ch]) / 1000;
      end else if (!mld[ch] || mk[ch] == 0) begin
        m_err = 1'b1;
      end else begin
        t = (raw * 1000 - mo[ch]) / mk[ch];
        if (t < 0) m_mis = (t < -10);
        else m_data = (t * mg[ch]) / 1000;
      end
    end
  endfunction

  always @(negedge clk) if (rst_n) begin
    check("R1", "cmd_ready", longint'(cmd_ready), longint'(m_ready));
    check("R3", "res_valid", longint'(res_valid), longint'(m_rv));
    if (m_rv && res_valid) begin
      check(tag, "res_data", longint'($signed(res_data)), m_data);
      check(tag, "res_err", longint'(res_err), longint'(m_err));
      check(tag, "res_mismatch", longint'(res_mismatch), longint'(m_mis));
    end
    if (cmd_valid && m_ready) begin
      m_ready = 1'b0;
      m_cnt = LAT + 1;
      model_accept();
    end
    if (m_rv && res_ready) begin
      m_rv = 1'b0;
      m_ready = 1'b1;
    end
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) m_rv = 1'b1;
    end
  end

  task automatic run(input logic op, input int ch, input int raw,
                     input int x1, input int x2, input int v1, input int v2,
                     input int d1, input int d2, input int hold, input string t);
    @(posedge clk); #2;
    tag = t;
    cmd_op = op; cmd_chan = 4'(ch); cmd_raw = 12'(raw);
    cmd_x1 = 12'(x1); cmd_x2 = 12'(x2); cmd_v1 = 16'(v1); cmd_v2 = 16'(v2);
    cmd_d1 = 16'(d1); cmd_d2 = 16'(d2);
    cmd_valid = 1'b1;
    forever begin @(negedge clk); if (cmd_ready) break; end
    @(posedge clk); #2 cmd_valid = 1'b0;
    forever begin @(negedge clk); if (res_valid) break; end
    repeat (hold) @(posedge clk);
    @(posedge clk); #2 res_ready = 1'b1;
    @(posedge clk); #2 res_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R11", "reset cmd_ready", longint'(cmd_ready), 1);
    check("R11", "reset res_valid", longint'(res_valid), 0);
    // R11: an uncalibrated channel starts with gain 0
    run(1'b1, 13, 4000, 0, 0, 0, 0, 0, 0, 0, "R11");
    // R4: calibrate channel 0, positive trims
    run(1'b0, 0, 0, 2064, 3112, 630, 950, 5, 12, 0, "R4");
    // R5: correct channel 0, two raw codes, second with back-pressure (R2)
    run(1'b1, 0, 2500, 0, 0, 0, 0, 0, 0, 0, "R5");
    run(1'b1, 0, 4095, 0, 0, 0, 0, 0, 0, 6, "R2");
    // R4: negative trim difference truncates toward zero
    run(1'b0, 6, 0, 2064, 3112, 2520, 3800, -20, -30, 1, "R4");
    run(1'b1, 6, 3000, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R6: large positive lower trim makes low codes negative
    run(1'b0, 2, 0, 2064, 3112, 1260, 1900, 40, 44, 0, "R4");
    run(1'b1, 2, 5, 0, 0, 0, 0, 0, 0, 0, "R6");
    run(1'b1, 2, 30, 0, 0, 0, 0, 0, 0, 0, "R6");
    run(1'b1, 2, 33, 0, 0, 0, 0, 0, 0, 0, "R6");
    run(1'b1, 2, 1000, 0, 0, 0, 0, 0, 0, 2, "R5");
    // R7: masked channel applies gain only
    run(1'b0, 11, 0, 2064, 3112, 630, 950, 900, -900, 0, "R7");
    run(1'b1, 11, 4095, 0, 0, 0, 0, 0, 0, 0, "R7");
    run(1'b1, 11, 3, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R9: never-calibrated channel outside the mask
    run(1'b1, 5, 2000, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R9: stored gain-error of exactly zero
    run(1'b0, 7, 0, 2064, 3112, 2520, 3800, 1048, 0, 0, "R9");
    run(1'b1, 7, 2000, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R8: equal ideal codes rejected, channel 0 keeps its terms
    run(1'b0, 0, 0, 2064, 2064, 100, 4000, 300, 900, 3, "R8");
    run(1'b1, 0, 2500, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R10: another channel's calibration leaves channel 0 alone
    run(1'b0, 1, 0, 1000, 3000, 500, 4500, -7, 9, 0, "R10");
    run(1'b1, 1, 1500, 0, 0, 0, 0, 0, 0, 0, "R10");
    run(1'b1, 0, 2500, 0, 0, 0, 0, 0, 0, 0, "R10");
    run(1'b1, 6, 3000, 0, 0, 0, 0, 0, 0, 0, "R10");
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule